// File: doc/BRIEF.md
# Status Flag Register with Single-Bit Set/Clear

This block keeps the eight processor condition and control flags in one register. It decodes a 16-bit instruction word. When the word carries the single-bit set or single-bit clear form, the block forces one flag bit to 1 or 0 and leaves the other seven bits as they were. The short per-flag mnemonics (set carry, clear interrupt enable and the rest) reach the block as this same encoding with a fixed bit index, so they need no decode of their own.

A neighbouring arithmetic unit writes result flags through a per-bit masked parallel port in the same cycle. Every change appears after one rising clock edge. The whole register and each named flag are brought out as outputs.

Top module: `sreg_bitops`

## Requirements
- R1: An active-low asynchronous reset clears the register to 8'h00, so the interrupt-enable flag reads 0 after reset.
- R2: A valid word matching 1001_0100_0sss_1000 (16'h9408 | sss<<4) sets bit sss to 1 at the next rising edge.
- R3: A valid word matching 1001_0100_1sss_1000 (16'h9488 | sss<<4) clears bit sss to 0 at the next rising edge.
- R4: A set or clear word changes only the selected bit; the other seven bits keep their values.
- R5: A word that does not match either form, or any word with op_valid_i low, leaves the register unchanged when no arithmetic write is present.
- R6: For each bit n with alu_wmask_i[n]=1, the bit takes alu_flags_i[n] at the next edge; bits whose mask bit is 0 keep their values.
- R7: When a set/clear word and an arithmetic write arrive in the same cycle, the selected bit takes the set/clear value, and the other masked bits still take their arithmetic values.
- R8: The named flag outputs show the register bits at fixed positions: 7 interrupt enable, 6 T, 5 half carry, 4 sign, 3 overflow, 2 negative, 1 zero, 0 carry.
- R9: Each operation completes in one cycle, so back-to-back words on consecutive cycles each take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Instruction word is valid this cycle |
| op_word_i | input | 16 | Instruction word |
| alu_wmask_i | input | 8 | Per-bit write enable from the arithmetic unit |
| alu_flags_i | input | 8 | Flag values from the arithmetic unit |
| status_o | output | 8 | Register contents |
| int_en_o | output | 1 | Interrupt enable flag (bit 7) |
| tbit_o | output | 1 | T flag (bit 6) |
| half_carry_o | output | 1 | Half carry flag (bit 5) |
| sign_o | output | 1 | Sign flag (bit 4) |
| overflow_o | output | 1 | Overflow flag (bit 3) |
| negative_o | output | 1 | Negative flag (bit 2) |
| zero_o | output | 1 | Zero flag (bit 1) |
| carry_o | output | 1 | Carry flag (bit 0) |

## Verification
The assertions assume that op_word_i and the arithmetic inputs hold a known value on every clock edge outside reset. They also assume that the arithmetic mask is the only way flags change besides the decoded word. The bench drives every input on the falling edge, so the values are settled and defined before each rising edge. Its stimulus includes unmatched words that are one bit away from the pattern, valid-low words, and collisions on the selected bit, so each property's antecedent is reached.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int SREG_W = 8;
  localparam int IDX_W  = $clog2(SREG_W);
  localparam int WORD_W = 16;

  typedef enum logic [IDX_W-1:0] {
    FLAG_C = 3'd0,
    FLAG_Z = 3'd1,
    FLAG_N = 3'd2,
    FLAG_V = 3'd3,
    FLAG_S = 3'd4,
    FLAG_H = 3'd5,
    FLAG_T = 3'd6,
    FLAG_I = 3'd7
  } flag_pos_e;

  typedef struct packed {
    logic             hit;
    logic             clr;
    logic [IDX_W-1:0] idx;
  } bitop_t;
endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
  import sreg_pkg::*;
#(
  parameter logic [7:0] OPC_HI = 8'h94,
  parameter logic [3:0] OPC_LO = 4'h8
) (
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output bitop_t            op_o
);
  logic match;

  assign match     = valid_i && (word_i[15:8] == OPC_HI) && (word_i[3:0] == OPC_LO);
  assign op_o.hit  = match;
  assign op_o.clr  = word_i[7];
  assign op_o.idx  = word_i[6:4];
endmodule

// File: rtl/sreg_merge.sv
module sreg_merge
  import sreg_pkg::*;
(
  input  bitop_t            op_i,
  input  logic [SREG_W-1:0] cur_i,
  input  logic [SREG_W-1:0] alu_mask_i,
  input  logic [SREG_W-1:0] alu_val_i,
  output logic [SREG_W-1:0] nxt_o
);
  logic [SREG_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (op_i.hit) sel[op_i.idx] = 1'b1;
  end

  for (genvar b = 0; b < SREG_W; b++) begin : g_bit
    // bit operation outranks the arithmetic write on its own bit
    always_comb begin
      if (sel[b])              nxt_o[b] = ~op_i.clr;
      else if (alu_mask_i[b])  nxt_o[b] = alu_val_i[b];
      else                     nxt_o[b] = cur_i[b];
    end
  end
endmodule

// File: rtl/sreg_store.sv
module sreg_store
  import sreg_pkg::*;
#(
  parameter logic [SREG_W-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SREG_W-1:0] d_i,
  output logic [SREG_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/sreg_bitops.sv
module sreg_bitops
  import sreg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        op_valid_i,
  input  logic [15:0] op_word_i,
  input  logic [7:0]  alu_wmask_i,
  input  logic [7:0]  alu_flags_i,
  output logic [7:0]  status_o,
  output logic        int_en_o,
  output logic        tbit_o,
  output logic        half_carry_o,
  output logic        sign_o,
  output logic        overflow_o,
  output logic        negative_o,
  output logic        zero_o,
  output logic        carry_o
);
  bitop_t            op;
  logic [SREG_W-1:0] nxt;
  logic [SREG_W-1:0] cur;

  sreg_decode u_dec (
    .valid_i (op_valid_i),
    .word_i  (op_word_i),
    .op_o    (op)
  );

  sreg_merge u_merge (
    .op_i       (op),
    .cur_i      (cur),
    .alu_mask_i (alu_wmask_i),
    .alu_val_i  (alu_flags_i),
    .nxt_o      (nxt)
  );

  sreg_store u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (nxt),
    .q_o    (cur)
  );

  assign status_o     = cur;
  assign int_en_o     = cur[FLAG_I];
  assign tbit_o       = cur[FLAG_T];
  assign half_carry_o = cur[FLAG_H];
  assign sign_o       = cur[FLAG_S];
  assign overflow_o   = cur[FLAG_V];
  assign negative_o   = cur[FLAG_N];
  assign zero_o       = cur[FLAG_Z];
  assign carry_o      = cur[FLAG_C];
endmodule

// File: rtl/sreg_bitops_chk.sv
module sreg_bitops_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        op_valid_i,
  input logic [15:0] op_word_i,
  input logic [7:0]  alu_wmask_i,
  input logic [7:0]  alu_flags_i,
  input logic [7:0]  status_o
);
  logic       is_op;
  logic [7:0] onehot;

  assign is_op  = op_valid_i && (op_word_i[15:8] == 8'h94) && (op_word_i[3:0] == 4'h8);
  assign onehot = 8'h01 << op_word_i[6:4];

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> status_o == 8'h00);

  assert_set_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_op && !op_word_i[7] |=> (status_o & $past(onehot)) != 8'h00);

  assert_clr_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_op && op_word_i[7] |=> (status_o & $past(onehot)) == 8'h00);

  assert_others_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_op && alu_wmask_i == 8'h00 |=>
      (status_o & ~$past(onehot)) == ($past(status_o) & ~$past(onehot)));

  assert_idle_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_op && alu_wmask_i == 8'h00 |=> $stable(status_o));

  assert_alu_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_op |=> (status_o & $past(alu_wmask_i)) == ($past(alu_flags_i) & $past(alu_wmask_i)));

  assert_op_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_op && (alu_wmask_i & onehot) != 8'h00 |=>
      ((status_o & $past(onehot)) != 8'h00) == !$past(op_word_i[7]));
endmodule

bind sreg_bitops sreg_bitops_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_valid_i  (op_valid_i),
  .op_word_i   (op_word_i),
  .alu_wmask_i (alu_wmask_i),
  .alu_flags_i (alu_flags_i),
  .status_o    (status_o)
);

// File: tb/sreg_bitops_tb_top.sv
`timescale 1ns/1ps
module sreg_bitops_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [15:0] op_word_i = 16'h0000;
  logic [7:0]  alu_wmask_i = 8'h00;
  logic [7:0]  alu_flags_i = 8'h00;
  logic [7:0]  status_o;
  logic        int_en_o, tbit_o, half_carry_o, sign_o;
  logic        overflow_o, negative_o, zero_o, carry_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] ref_q = 8'h00;

  always #2.5 clk_i = ~clk_i;

  sreg_bitops dut_i (
    .clk_i, .rst_ni, .op_valid_i, .op_word_i, .alu_wmask_i, .alu_flags_i,
    .status_o, .int_en_o, .tbit_o, .half_carry_o, .sign_o,
    .overflow_o, .negative_o, .zero_o, .carry_o
  );

  task automatic check(input string req);
    logic [7:0] named;
    named = {int_en_o, tbit_o, half_carry_o, sign_o,
             overflow_o, negative_o, zero_o, carry_o};
    checks++;
    if (status_o !== ref_q) begin
      errors++;
      $display("FAIL %s status actual=%h expected=%h", req, status_o, ref_q);
    end
    checks++;
    if (named !== ref_q) begin
      errors++;
      $display("FAIL R8 named flags actual=%h expected=%h (%s)", named, ref_q, req);
    end
  endtask

  // reference: arithmetic bits first, then a decoded set/clear overrides its bit
  task automatic step(input logic v, input logic [15:0] w, input logic [7:0] m,
                      input logic [7:0] f, input string req);
    op_valid_i = v; op_word_i = w; alu_wmask_i = m; alu_flags_i = f;
    @(posedge clk_i);
    for (int b = 0; b < 8; b++) if (m[b]) ref_q[b] = f[b];
    if (v && w[15:8] == 8'h94 && w[3:0] == 4'h8) ref_q[w[6:4]] = ~w[7];
    @(negedge clk_i);
    check(req);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1");
    // R2 R4 R9: set each bit, back to back
    for (int i = 0; i < 8; i++) step(1'b1, 16'h9408 | (16'(i) << 4), 8'h00, 8'h00, "R2");
    // R3 R4 R9: clear each bit
    for (int i = 7; i >= 0; i--) step(1'b1, 16'h9488 | (16'(i) << 4), 8'h00, 8'h00, "R3");
    // aliases: set carry, set interrupt enable, clear interrupt enable, set zero
    step(1'b1, 16'h9408, 8'h00, 8'h00, "R2");
    step(1'b1, 16'h9478, 8'h00, 8'h00, "R2");
    step(1'b1, 16'h9418, 8'h00, 8'h00, "R4");
    step(1'b1, 16'h94F8, 8'h00, 8'h00, "R3");
    // R5: near misses and valid low
    step(1'b1, 16'h9409, 8'h00, 8'h00, "R5");
    step(1'b1, 16'h9508, 8'h00, 8'h00, "R5");
    step(1'b1, 16'h9488 | 16'h0100, 8'h00, 8'h00, "R5");
    step(1'b1, 16'h0000, 8'h00, 8'h00, "R5");
    step(1'b0, 16'h9488, 8'h00, 8'h00, "R5");
    step(1'b0, 16'h9478, 8'h00, 8'h00, "R5");
    // R6: masked arithmetic writes
    step(1'b0, 16'h0000, 8'hFF, 8'hA5, "R6");
    step(1'b0, 16'h0000, 8'h0F, 8'h50, "R6");
    step(1'b0, 16'h0000, 8'h3C, 8'hFF, "R6");
    step(1'b1, 16'h9509, 8'h81, 8'h00, "R6");
    // R7: collisions on the selected bit and neighbours
    step(1'b1, 16'h9408, 8'hFF, 8'h00, "R7");
    step(1'b1, 16'h94B8, 8'h0F, 8'hFF, "R7");
    step(1'b1, 16'h9478, 8'h80, 8'h00, "R7");
    step(1'b1, 16'h94F8, 8'hC0, 8'hC0, "R7");
    step(1'b1, 16'h9428, 8'h04, 8'h00, "R7");
    // R1: asynchronous reset mid-run
    step(1'b0, 16'h0000, 8'hFF, 8'hFF, "R6");
    #1 rst_ni = 1'b0;
    #0.5 ref_q = 8'h00;
    check("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b0, 16'h0000, 8'h00, 8'h00, "R1");
    step(1'b1, 16'h9438, 8'h00, 8'h00, "R2");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule